// File: doc/BRIEF.md
# 128-by-64 Unsigned Divide-Modulo Unit

This unit divides a 128-bit unsigned dividend by a 64-bit unsigned divisor and returns the quotient and the remainder in one response. The dividend is built from two operands: operand A is its upper half and operand C its lower half. Operand B is the divisor. Each request carries a destination register index. The quotient is tagged with that index, and the remainder is tagged with the index plus one, so the two results can fill a consecutive register pair.

The quotient fits in 64 bits only when A is strictly below B. This also rules out a zero divisor. The unit tests for this when it accepts a request. If the test fails, it skips the datapath and answers on the next cycle with a quotient of all ones and a remainder of zero. Software tells this case apart by comparing the results. No flag is raised. In the normal case a restoring shift-subtract loop runs one iteration per clock for 64 clocks. Requests and responses each use a valid/ready handshake, and the unit holds only one operation at a time.

Top module: `divmod_unit`

## Requirements
- R1: When A < B (unsigned) and B != 0, rspQuo equals bits 63:0 of ({A,C} / B) and rspRem equals bits 63:0 of ({A,C} mod B), where A forms dividend bits 127:64 and C forms bits 63:0.
- R2: When B == 0, the response carries rspQuo = all ones and rspRem = 0.
- R3: When A >= B and B != 0, the response carries rspQuo = all ones and rspRem = 0.
- R4: A request accepted under the R2/R3 conditions raises rspValid immediately after the accepting clock edge.
- R5: A request accepted under the R1 condition raises rspValid immediately after the 64th clock edge following the accepting edge.
- R6: reqReady is high only when no operation is running and no response is pending. A reqValid presented while reqReady is low has no effect on the pending response.
- R7: While rspValid is high and rspReady is low, rspValid, rspQuo, rspRem and both destination indices hold their values.
- R8: rspDestLo equals the reqDest captured at acceptance, and rspDestHi equals rspDestLo + 1 modulo 2^IDX_W.
- R9: After reset, reqReady is 1 and rspValid is 0.
- R10: After a clock edge at which rspValid and rspReady are both high, rspValid is 0 and reqReady is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit idle, able to take a request |
| opA | input | W | Upper half of dividend |
| opB | input | W | Divisor |
| opC | input | W | Lower half of dividend |
| reqDest | input | IDX_W | Destination index for quotient |
| rspValid | output | 1 | Response available |
| rspReady | input | 1 | Consumer takes response |
| rspQuo | output | W | Quotient or all-ones saturation value |
| rspRem | output | W | Remainder or zero |
| rspDestLo | output | IDX_W | Index for the quotient |
| rspDestHi | output | IDX_W | Index for the remainder (rspDestLo + 1) |

## Verification
If the iteration counter is wrong, the response arrives early or late, and the bench measures latency to the exact cycle. A partial remainder that is corrupted in any iteration gives a wrong quotient or remainder. This shows up in the very response that follows, because every result is compared with a 128-bit reference division. A bad overflow test on acceptance shows one of two ways: a one-cycle saturated reply where a 64-cycle division was expected, or the reverse. Response-holding faults show while the consumer is kept stalled for several cycles.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
  // Strobes issued by the sequencer to the datapath each cycle
  typedef struct packed {
    logic load;  // capture operands and destination
    logic sat;   // with load: write saturated result instead of operands
    logic step;  // perform one shift-subtract iteration
  } dmStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dmState_t;
endpackage

// File: rtl/divmod_dpath.sv
module divmod_dpath
  import divmod_pkg::*;
#(
  parameter int W     = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmStrobe_t        strobe,
  input  logic [W-1:0]     opA,
  input  logic [W-1:0]     opB,
  input  logic [W-1:0]     opC,
  input  logic [IDX_W-1:0] reqDest,
  output logic             opBad,
  output logic [W-1:0]     rspQuo,
  output logic [W-1:0]     rspRem,
  output logic [IDX_W-1:0] rspDestLo,
  output logic [IDX_W-1:0] rspDestHi
);
  logic [W-1:0]     remReg;   // partial remainder, always below divReg while running
  logic [W-1:0]     quoReg;   // holds remaining low dividend bits, then quotient bits
  logic [W-1:0]     divReg;
  logic [IDX_W-1:0] destReg;

  logic [W:0]   trial;
  logic         fits;
  logic [W:0]   diff;
  logic [W-1:0] remNext;

  // Quotient overflows 64 bits (or divisor is zero) unless A < B
  assign opBad = (opB == '0) || (opA >= opB);

  always_comb begin
    trial   = {remReg, quoReg[W-1]};
    fits    = (trial >= {1'b0, divReg});
    diff    = trial - {1'b0, divReg};
    remNext = fits ? diff[W-1:0] : trial[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      quoReg  <= '0;
      divReg  <= '0;
      destReg <= '0;
    end else if (strobe.load) begin
      destReg <= reqDest;
      divReg  <= opB;
      if (strobe.sat) begin
        remReg <= '0;
        quoReg <= '1;
      end else begin
        remReg <= opA;
        quoReg <= opC;
      end
    end else if (strobe.step) begin
      remReg <= remNext;
      quoReg <= {quoReg[W-2:0], fits};
    end
  end

  assign rspQuo    = quoReg;
  assign rspRem    = remReg;
  assign rspDestLo = destReg;
  assign rspDestHi = destReg + IDX_W'(1);

  // R1: the restoring loop keeps the partial remainder below the divisor
  p_rem_below_div_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (remReg < divReg));
endmodule

// File: rtl/divmod_ctrl.sv
module divmod_ctrl
  import divmod_pkg::*;
#(
  parameter int W = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      opBad,
  input  logic      rspReady,
  output logic      reqReady,
  output logic      rspValid,
  output dmStrobe_t strobe
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  dmState_t         state, nextState;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        strobe.sat  = opBad;
        nextState   = opBad ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (cnt == LAST) nextState = ST_DONE;
      end
      ST_DONE: if (rspReady) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (strobe.load)      cnt <= '0;
      else if (strobe.step) cnt <= cnt + CNT_W'(1);
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_DONE);

  // R5: a valid request enters the loop with a cleared counter
  p_run_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !opBad) |=> (state == ST_RUN && cnt == '0));
  // R5: the loop does not leave before its last iteration
  p_run_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cnt != LAST) |=> (state == ST_RUN));
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import divmod_pkg::*;
#(
  parameter int W     = 64,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [W-1:0]     opA,
  input  logic [W-1:0]     opB,
  input  logic [W-1:0]     opC,
  input  logic [IDX_W-1:0] reqDest,
  output logic             rspValid,
  input  logic             rspReady,
  output logic [W-1:0]     rspQuo,
  output logic [W-1:0]     rspRem,
  output logic [IDX_W-1:0] rspDestLo,
  output logic [IDX_W-1:0] rspDestHi
);
  dmStrobe_t strobe;
  logic      opBad;

  divmod_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opBad(opBad),
    .rspReady(rspReady), .reqReady(reqReady), .rspValid(rspValid),
    .strobe(strobe)
  );

  divmod_dpath #(.W(W), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .opC(opC), .reqDest(reqDest), .opBad(opBad), .rspQuo(rspQuo),
    .rspRem(rspRem), .rspDestLo(rspDestLo), .rspDestHi(rspDestHi)
  );

  // R2 R3 R4: out-of-range operands give a saturated reply one cycle later
  p_sat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(opA < opB)) |=>
      (rspValid && rspQuo == '1 && rspRem == '0));
  // R6: never accepting while a response is pending
  p_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && rspValid));
  // R7: stalled response holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspQuo) &&
      $stable(rspRem) && $stable(rspDestLo) && $stable(rspDestHi)));
  // R8: remainder index follows quotient index
  p_dest_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspDestHi == rspDestLo + IDX_W'(1)));
  // R10: accepted response releases the unit
  p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> (!rspValid && reqReady));
endmodule

// File: tb/tb_divmod_unit.sv
module tb_divmod_unit;
  localparam int W     = 64;
  localparam int IDX_W = 5;
  localparam int NV    = 8;

  // Stimulus table: {A, B, C}; expected results come from a 128-bit reference
  localparam logic [3*W-1:0] VEC [NV] = '{
    {64'd7,                 64'd10,                 64'd12345},
    {64'd0,                 64'd1,                  64'hDEADBEEF_CAFEF00D},
    {64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'd5,                 64'd0,                  64'd1},
    {64'h1234,              64'h1234,               64'd0},
    {64'h9000,              64'h8000,               64'h55},
    {64'h0FFF,              64'h1000,               64'hFFFF_FFFF_FFFF_FFFF},
    {64'd0,                 64'd0,                  64'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, rspReady = 1'b0;
  logic [W-1:0] opA = '0, opB = '0, opC = '0;
  logic [IDX_W-1:0] reqDest = '0;
  logic reqReady, rspValid;
  logic [W-1:0] rspQuo, rspRem;
  logic [IDX_W-1:0] rspDestLo, rspDestHi;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  divmod_unit #(.W(W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .opA(opA), .opB(opB), .opC(opC), .reqDest(reqDest),
    .rspValid(rspValid), .rspReady(rspReady), .rspQuo(rspQuo),
    .rspRem(rspRem), .rspDestLo(rspDestLo), .rspDestHi(rspDestHi)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One full transaction; poke presents a competing request while busy
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [IDX_W-1:0] d,
                       input bit poke, input int stall);
    logic [127:0] dvd, q, r;
    logic [W-1:0] expQ, expR;
    bit bad;
    int lat;
    logic [W-1:0] holdQ, holdR;
    dvd  = {a, c};
    bad  = (b == '0) || (a >= b);
    if (bad) begin
      expQ = '1; expR = '0;
    end else begin
      q = dvd / {64'd0, b};
      r = dvd % {64'd0, b};
      expQ = q[W-1:0]; expR = r[W-1:0];
    end
    @(negedge clk);
    opA = a; opB = b; opC = c; reqDest = d; reqValid = 1'b1;
    chk(reqReady == 1'b1, "R6 ready when idle", 128'(reqReady), 128'd1);
    @(negedge clk);
    if (poke) begin
      opA = ~a; opB = 64'd3; opC = 64'd9; reqDest = d + 5'd3;
      if (!rspValid)
        chk(reqReady == 1'b0, "R6 not ready while busy", 128'(reqReady), 128'd0);
    end else begin
      reqValid = 1'b0;
    end
    lat = 0;
    while (!rspValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    if (bad) chk(lat == 0, "R4 saturated latency", 128'(lat), 128'd0);
    else     chk(lat == W, "R5 divide latency", 128'(lat), 128'(W));
    chk(rspQuo == expQ, bad ? "R2/R3 quotient" : "R1 quotient", 128'(rspQuo), 128'(expQ));
    chk(rspRem == expR, bad ? "R2/R3 remainder" : "R1 remainder", 128'(rspRem), 128'(expR));
    chk(rspDestLo == d, "R8 quotient index", 128'(rspDestLo), 128'(d));
    chk(rspDestHi == IDX_W'(d + 1), "R8 remainder index", 128'(rspDestHi), 128'(IDX_W'(d + 1)));
    holdQ = rspQuo; holdR = rspRem;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rspValid && rspQuo == holdQ && rspRem == holdR && rspDestLo == d,
          "R7 hold while stalled", {rspQuo, rspRem}, {holdQ, holdR});
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, "R10 release after accept",
        128'({rspValid, reqReady}), 128'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1 && rspValid == 1'b0, "R9 reset state",
        128'({reqReady, rspValid}), 128'b10);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && rspValid == 1'b0, "R9 after reset",
        128'({reqReady, rspValid}), 128'b10);

    for (int i = 0; i < NV; i++)
      runOp(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0],
            IDX_W'(i * 5), 1'b0, 1);

    // Directed corner cases
    runOp(64'd100, 64'd0, 64'd5, 5'd31, 1'b1, 2);          // R2 zero divisor, index wrap
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'd4, 1'b0, 0); // R3 A==B
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0, 5'd6, 1'b0, 0); // R3 A>B
    runOp(64'h7FFF, 64'h8000, 64'hFFFF_FFFF_FFFF_FFFF, 5'd30, 1'b1, 3); // R1 A==B-1, C ones, R6 poke

    // Randomized valid divisions
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] rb, ra, rc;
      rb = {$urandom, $urandom};
      if (k % 4 == 0) rb = 64'($urandom) + 64'd1;
      if (rb == '0) rb = 64'd1;
      ra = {$urandom, $urandom} % rb;
      rc = {$urandom, $urandom};
      runOp(ra, rb, rc, IDX_W'($urandom), k[0], k % 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule